// File: doc/BRIEF.md
# Compressed Instruction Expander

This unit sits between an instruction store and the processor's fetch port. The store holds a dense bitstream of variable-length compressed instructions, laid out back to back with no alignment between them. The unit pulls this stream in as 32-bit fetch words and keeps it in a bit-level shift buffer. It reads the prefix code at the head of the buffer and sorts each instruction into one of four classes: immediate, branch, dictionary or raw. It then rebuilds the full 32-bit instruction word and hands it to the processor through a valid/ready output register.

A jump target in the compressed image always starts on a byte boundary. A redirect therefore carries a byte address. It empties the buffer, restarts fetching at the word that holds that byte, and drops the leading bytes of that word. Before decoding starts, two tables are loaded through a configuration write port: a dictionary of whole instruction words, and a set of instruction templates used by the immediate class.

The controller has three states. `ST_IDLE` holds after reset: it makes no fetches and accepts table writes. The *start* transition goes to `ST_SEEK` on the first redirect. `ST_SEEK` waits for the first fetch word at the target and takes the *land* transition to `ST_STREAM` when that word is accepted. `ST_STREAM` decodes continuously. A redirect in `ST_SEEK` or `ST_STREAM` is the *jump* transition back to `ST_SEEK`.

Top module: `cx_top`

## Requirements
- R1: Immediate class. The first bit is 0. It is followed by a 4-bit template index and then a 13-bit immediate, so the instruction is 18 bits long. The output is the indexed template word with bits 12:0 replaced by the immediate.
- R2: Branch class. The first two bits are 11. They are followed by a 4-bit condition and then a 16-bit signed offset, 22 bits in all. The output has bits 31:29 = 000, the condition in bits 28:25, bits 24:22 = 010, and the sign-extended offset in bits 21:0. The offset passes through without any arithmetic.
- R3: Dictionary class. The first three bits are 100, followed by an 8-bit index, 11 bits in all. The output is the dictionary entry at that index.
- R4: Raw class. The first three bits are 101, followed by 32 bits that are output unchanged, 35 bits in all.
- R5: The stream is read most significant bit first. Bit 31 of a fetch word comes before bit 0, and fetch word n+1 follows fetch word n. Instructions are packed with no gaps and may span word boundaries. Byte k of a word is bits 31-8k down to 24-8k.
- R6: A redirect to byte address b empties the buffer. In the next cycle `fetch_addr` equals b/4. Decoding begins 8·(b mod 4) bits into that word.
- R7: The cycle after a redirect, `out_valid` is low, and any output still waiting is discarded. The first word that follows is the first instruction at the target.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_instr` hold steady. Every instruction is delivered once, in stream order, under any pattern of output and fetch stalls.
- R9: `fetch_ready` is high only outside `ST_IDLE`, only outside a redirect cycle, and only when fewer than 35 bits are valid. The buffer never holds more than 66 bits.
- R10: After reset the unit is in `ST_IDLE`, with `fetch_ready` and `out_valid` low. In that state a write with `cfg_we` high stores `cfg_data`. With `cfg_tbl` = 0 it goes into dictionary entry `cfg_addr`. With `cfg_tbl` = 1 it goes into template `cfg_addr[3:0]`.
- R11: Table writes made outside `ST_IDLE` are ignored, and later lookups return the earlier contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Table write enable (effective in `ST_IDLE` only) |
| cfg_tbl | input | 1 | Table select: 0 dictionary, 1 template |
| cfg_addr | input | 8 | Table entry index |
| cfg_data | input | 32 | Table entry data |
| redirect_valid | input | 1 | Restart decoding at `redirect_addr` |
| redirect_addr | input | ADDR_W | Byte address of the new block |
| fetch_ready | output | 1 | Unit can accept a fetch word this cycle |
| fetch_addr | output | ADDR_W-2 | Word address being requested |
| fetch_valid | input | 1 | `fetch_data` holds the word at `fetch_addr` |
| fetch_data | input | 32 | Fetch word |
| out_valid | output | 1 | `out_instr` holds an expanded instruction |
| out_ready | input | 1 | Processor accepts the instruction |
| out_instr | output | 32 | Expanded 32-bit instruction |

## Verification
The main pass decodes a long stream that walks through every dictionary index, every template with extreme and mixed immediates, every branch condition with the most positive and most negative offsets, and raw words of all ones and mixed bits. These classes are interleaved so that instructions of every length fall across fetch-word boundaries. A wrong field slice, a wrong length, or a slip in the buffer refill each shows up as a mismatch in the expanded words. Further blocks are entered by redirects whose byte offset within the word is 1, 2, 3 and 0, which separates a correct skip from an off-by-a-byte error. Output back-pressure and fetch gaps run throughout. A dictionary write made mid-stream must leave a later lookup returning the original entry.

// File: rtl/cx_pkg.sv
package cx_pkg;
    localparam int WORD_W     = 32;
    localparam int DICT_IDX_W = 8;
    localparam int DICT_N     = 1 << DICT_IDX_W;
    localparam int TPL_IDX_W  = 4;
    localparam int TPL_N      = 1 << TPL_IDX_W;
    localparam int IMM_W      = 13;
    localparam int COND_W     = 4;
    localparam int OFS_W      = 16;
    localparam int BR_OFS_W   = 22;
    localparam int LEN_IMM    = 1 + TPL_IDX_W + IMM_W;
    localparam int LEN_BR     = 2 + COND_W + OFS_W;
    localparam int LEN_DICT   = 3 + DICT_IDX_W;
    localparam int LEN_RAW    = 3 + WORD_W;
    localparam int MAX_LEN    = LEN_RAW;
    localparam int BUF_W      = MAX_LEN + WORD_W - 1;
    localparam int CNT_W      = $clog2(BUF_W + 1);
    localparam int SKIP_W     = $clog2(WORD_W);

    typedef enum logic [1:0] {
        CLS_IMM  = 2'd0,
        CLS_BR   = 2'd1,
        CLS_DICT = 2'd2,
        CLS_RAW  = 2'd3
    } cls_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SEEK   = 2'd1,
        ST_STREAM = 2'd2
    } st_e;
endpackage

// File: rtl/cx_bitbuf.sv
module cx_bitbuf
    import cx_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic               push,
    input  logic [WORD_W-1:0]  push_word,
    input  logic [SKIP_W-1:0]  push_skip,
    input  logic               pop,
    input  logic [CNT_W-1:0]   pop_len,
    output logic [MAX_LEN-1:0] win,
    output logic [CNT_W-1:0]   cnt
);
    logic [BUF_W-1:0] bits_q, kept, incoming;
    logic [CNT_W-1:0] cnt_q, cnt_kept, cnt_add;

    always_comb begin
        kept     = pop ? (bits_q << pop_len) : bits_q;
        cnt_kept = pop ? (cnt_q - pop_len) : cnt_q;
        incoming = '0;
        cnt_add  = '0;
        if (push) begin
            incoming = ({push_word, {(BUF_W-WORD_W){1'b0}}} << push_skip) >> cnt_kept;
            cnt_add  = CNT_W'(WORD_W) - CNT_W'(push_skip);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bits_q <= '0;
            cnt_q  <= '0;
        end else if (flush) begin
            bits_q <= '0;
            cnt_q  <= '0;
        end else begin
            bits_q <= kept | incoming;
            cnt_q  <= cnt_kept + cnt_add;
        end
    end

    assign win = bits_q[BUF_W-1 -: MAX_LEN];
    assign cnt = cnt_q;
endmodule

// File: rtl/cx_expand.sv
module cx_expand
    import cx_pkg::*;
(
    input  logic                  clk,
    input  logic                  tbl_we,
    input  logic                  tbl_sel,
    input  logic [DICT_IDX_W-1:0] tbl_addr,
    input  logic [WORD_W-1:0]     tbl_data,
    input  logic [MAX_LEN-1:0]    win,
    output cls_e                  cls,
    output logic [CNT_W-1:0]      ins_len,
    output logic [WORD_W-1:0]     ins_word
);
    localparam logic [2:0] BR_OP = 3'b010;

    logic [WORD_W-1:0] dict_mem [DICT_N];
    logic [WORD_W-1:0] tpl_mem  [TPL_N];

    always_ff @(posedge clk) begin
        if (tbl_we) begin
            if (tbl_sel) tpl_mem[tbl_addr[TPL_IDX_W-1:0]] <= tbl_data;
            else         dict_mem[tbl_addr]               <= tbl_data;
        end
    end

    logic [TPL_IDX_W-1:0]  tpl_idx;
    logic [IMM_W-1:0]      imm;
    logic [COND_W-1:0]     cond;
    logic [OFS_W-1:0]      ofs;
    logic [DICT_IDX_W-1:0] d_idx;
    logic [WORD_W-1:0]     raw;
    logic [WORD_W-1:0]     tpl_word;

    assign tpl_idx  = win[MAX_LEN-2 -: TPL_IDX_W];
    assign imm      = win[MAX_LEN-2-TPL_IDX_W -: IMM_W];
    assign cond     = win[MAX_LEN-3 -: COND_W];
    assign ofs      = win[MAX_LEN-3-COND_W -: OFS_W];
    assign d_idx    = win[MAX_LEN-4 -: DICT_IDX_W];
    assign raw      = win[MAX_LEN-4 -: WORD_W];
    assign tpl_word = tpl_mem[tpl_idx];

    always_comb begin
        if (!win[MAX_LEN-1])     cls = CLS_IMM;
        else if (win[MAX_LEN-2]) cls = CLS_BR;
        else if (win[MAX_LEN-3]) cls = CLS_RAW;
        else                     cls = CLS_DICT;
    end

    always_comb begin
        unique case (cls)
            CLS_IMM: begin
                ins_len  = CNT_W'(LEN_IMM);
                ins_word = {tpl_word[WORD_W-1:IMM_W], imm};
            end
            CLS_BR: begin
                ins_len  = CNT_W'(LEN_BR);
                ins_word = {3'b000, cond, BR_OP, {(BR_OFS_W-OFS_W){ofs[OFS_W-1]}}, ofs};
            end
            CLS_DICT: begin
                ins_len  = CNT_W'(LEN_DICT);
                ins_word = dict_mem[d_idx];
            end
            default: begin
                ins_len  = CNT_W'(LEN_RAW);
                ins_word = raw;
            end
        endcase
    end
endmodule

// File: rtl/cx_ctrl.sv
module cx_ctrl
    import cx_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               redirect_valid,
    input  logic [ADDR_W-1:0]  redirect_addr,
    input  logic               fetch_valid,
    output logic               fetch_ready,
    output logic [ADDR_W-3:0]  fetch_addr,
    input  logic [CNT_W-1:0]   buf_cnt,
    input  logic [CNT_W-1:0]   ins_len,
    input  logic [WORD_W-1:0]  ins_word,
    input  logic               out_ready,
    output logic               out_valid,
    output logic [WORD_W-1:0]  out_instr,
    output logic               flush,
    output logic               push,
    output logic [SKIP_W-1:0]  push_skip,
    output logic               pop,
    output st_e                state
);
    st_e               state_q, state_d;
    logic [ADDR_W-3:0] addr_q;
    logic [SKIP_W-1:0] skip_q;
    logic              valid_q;
    logic [WORD_W-1:0] instr_q;
    logic              complete;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (redirect_valid) state_d = ST_SEEK;
            ST_SEEK:   if (redirect_valid) state_d = ST_SEEK;
                       else if (push)      state_d = ST_STREAM;
            ST_STREAM: if (redirect_valid) state_d = ST_SEEK;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        flush       = redirect_valid;
        fetch_ready = (state_q != ST_IDLE) && !redirect_valid && (buf_cnt < CNT_W'(MAX_LEN));
        push        = fetch_ready && fetch_valid;
        push_skip   = (state_q == ST_SEEK) ? skip_q : '0;
        complete    = (state_q == ST_STREAM) && (buf_cnt >= ins_len);
        pop         = complete && !redirect_valid && (!valid_q || out_ready);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            skip_q  <= '0;
            valid_q <= 1'b0;
            instr_q <= '0;
        end else begin
            if (redirect_valid) begin
                addr_q <= redirect_addr[ADDR_W-1:2];
                skip_q <= {redirect_addr[1:0], 3'b000};
            end else if (push) begin
                addr_q <= addr_q + 1'b1;
            end
            if (redirect_valid) begin
                valid_q <= 1'b0;
            end else if (pop) begin
                valid_q <= 1'b1;
                instr_q <= ins_word;
            end else if (out_ready) begin
                valid_q <= 1'b0;
            end
        end
    end

    assign fetch_addr = addr_q;
    assign out_valid  = valid_q;
    assign out_instr  = instr_q;
    assign state      = state_q;
endmodule

// File: rtl/cx_top.sv
module cx_top
    import cx_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic                  cfg_tbl,
    input  logic [DICT_IDX_W-1:0] cfg_addr,
    input  logic [WORD_W-1:0]     cfg_data,
    input  logic                  redirect_valid,
    input  logic [ADDR_W-1:0]     redirect_addr,
    output logic                  fetch_ready,
    output logic [ADDR_W-3:0]     fetch_addr,
    input  logic                  fetch_valid,
    input  logic [WORD_W-1:0]     fetch_data,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic [WORD_W-1:0]     out_instr
);
    st_e               state;
    logic              flush, push, pop;
    logic [SKIP_W-1:0] push_skip;
    logic [MAX_LEN-1:0] win;
    logic [CNT_W-1:0]  buf_cnt, ins_len;
    logic [WORD_W-1:0] ins_word;
    cls_e              cls;
    logic              tbl_we;

    assign tbl_we = cfg_we && (state == ST_IDLE);

    cx_bitbuf u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .push      (push),
        .push_word (fetch_data),
        .push_skip (push_skip),
        .pop       (pop),
        .pop_len   (ins_len),
        .win       (win),
        .cnt       (buf_cnt)
    );

    cx_expand u_exp (
        .clk      (clk),
        .tbl_we   (tbl_we),
        .tbl_sel  (cfg_tbl),
        .tbl_addr (cfg_addr),
        .tbl_data (cfg_data),
        .win      (win),
        .cls      (cls),
        .ins_len  (ins_len),
        .ins_word (ins_word)
    );

    cx_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .redirect_valid (redirect_valid),
        .redirect_addr  (redirect_addr),
        .fetch_valid    (fetch_valid),
        .fetch_ready    (fetch_ready),
        .fetch_addr     (fetch_addr),
        .buf_cnt        (buf_cnt),
        .ins_len        (ins_len),
        .ins_word       (ins_word),
        .out_ready      (out_ready),
        .out_valid      (out_valid),
        .out_instr      (out_instr),
        .flush          (flush),
        .push           (push),
        .push_skip      (push_skip),
        .pop            (pop),
        .state          (state)
    );
endmodule

// File: rtl/cx_checks.sv
module cx_checks
    import cx_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              redirect_valid,
    input logic [ADDR_W-1:0] redirect_addr,
    input logic              fetch_ready,
    input logic              fetch_valid,
    input logic [ADDR_W-3:0] fetch_addr,
    input logic              out_valid,
    input logic              out_ready,
    input logic [WORD_W-1:0] out_instr,
    input logic [CNT_W-1:0]  buf_cnt,
    input st_e               state
);
    p_seq_fetch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_ready && fetch_valid && !redirect_valid) |=> (fetch_addr == ($past(fetch_addr) + 1'b1)));

    p_jump_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |=> (fetch_addr == $past(redirect_addr[ADDR_W-1:2])));

    p_jump_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |=> !out_valid);

    p_hold_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !redirect_valid) |=> (out_valid && $stable(out_instr)));

    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        buf_cnt <= CNT_W'(BUF_W));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (!fetch_ready && !out_valid));
endmodule

bind cx_top cx_checks #(.ADDR_W(ADDR_W)) u_checks (
    .clk            (clk),
    .rst_n          (rst_n),
    .redirect_valid (redirect_valid),
    .redirect_addr  (redirect_addr),
    .fetch_ready    (fetch_ready),
    .fetch_valid    (fetch_valid),
    .fetch_addr     (fetch_addr),
    .out_valid      (out_valid),
    .out_ready      (out_ready),
    .out_instr      (out_instr),
    .buf_cnt        (buf_cnt),
    .state          (state)
);

// File: tb/tb_cx_top.sv
module tb_cx_top;
    localparam int PERIOD    = 10;
    localparam int ADDR_W    = 16;
    localparam int MEM_WORDS = 256;
    localparam int MEM_BITS  = MEM_WORDS * 32;
    localparam int MAX_EXP   = 1024;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic              cfg_tbl = 1'b0;
    logic [7:0]        cfg_addr = '0;
    logic [31:0]       cfg_data = '0;
    logic              redirect_valid = 1'b0;
    logic [ADDR_W-1:0] redirect_addr = '0;
    logic              fetch_ready;
    logic [ADDR_W-3:0] fetch_addr;
    logic              fetch_valid = 1'b0;
    logic [31:0]       fetch_data;
    logic              out_valid;
    logic              out_ready = 1'b0;
    logic [31:0]       out_instr;

    always #(PERIOD/2) clk = ~clk;

    cx_top #(.ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_tbl(cfg_tbl),
        .cfg_addr(cfg_addr), .cfg_data(cfg_data),
        .redirect_valid(redirect_valid), .redirect_addr(redirect_addr),
        .fetch_ready(fetch_ready), .fetch_addr(fetch_addr),
        .fetch_valid(fetch_valid), .fetch_data(fetch_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_instr(out_instr)
    );

    logic [0:MEM_BITS-1] sbits;
    logic [31:0]         mem [MEM_WORDS];
    int                  pos = 0;
    logic [31:0]         exp_q [MAX_EXP];
    string               exp_req [MAX_EXP];
    int                  nexp = 0;
    int                  n_chk = 0;
    int                  n_fail = 0;
    int                  blk_byte [4];
    int                  blk_first [4];
    int                  blk_cnt [4];
    int                  n_main = 0;

    assign fetch_data = (fetch_addr < (ADDR_W-2)'(MEM_WORDS)) ? mem[fetch_addr[7:0]] : 32'h0;

    function automatic logic [31:0] dict_val(input int i);
        logic [7:0] b;
        b = i[7:0];
        return {b ^ 8'h5A, ~b, b + 8'd3, b};
    endfunction

    function automatic logic [31:0] tpl_val(input int t);
        return 32'hC0DE_0000 ^ (32'(t) * 32'h1111_1111);
    endfunction

    function automatic logic [31:0] raw_val(input int i);
        return (i == 0) ? 32'hFFFF_FFFF : (32'(i) * 32'h1357_9BDF);
    endfunction

    task automatic put(input logic [34:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            sbits[pos] = v[i];
            pos++;
        end
    endtask

    task automatic add_exp(input logic [31:0] w, input string r);
        exp_q[nexp]   = w;
        exp_req[nexp] = r;
        nexp++;
    endtask

    task automatic emit_imm(input int t, input logic [12:0] v, input string r);
        logic [31:0] tw;
        logic [3:0]  t4;
        t4 = t[3:0];
        tw = tpl_val(t);
        put(35'({1'b0, t4, v}), 18);
        add_exp({tw[31:13], v}, r);
    endtask

    task automatic emit_br(input int c, input logic [15:0] o, input string r);
        logic [3:0] c4;
        c4 = c[3:0];
        put(35'({2'b11, c4, o}), 22);
        add_exp({3'b000, c4, 3'b010, {6{o[15]}}, o}, r);
    endtask

    task automatic emit_dict(input int i, input string r);
        logic [7:0] i8;
        i8 = i[7:0];
        put(35'({3'b100, i8}), 11);
        add_exp(dict_val(i), r);
    endtask

    task automatic emit_raw(input logic [31:0] w, input string r);
        put({3'b101, w}, 35);
        add_exp(w, r);
    endtask

    task automatic align(input int k);
        while (((pos % 8) != 0) || (((pos / 8) % 4) != k)) begin
            sbits[pos] = 1'b0;
            pos++;
        end
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic run_block(input int baddr, input int first, input int n);
        int          got;
        int          spins;
        int          phase;
        logic        rdy;
        logic        held;
        logic [31:0] held_val;
        @(negedge clk);
        out_ready      = 1'b0;
        redirect_valid = 1'b1;
        redirect_addr  = ADDR_W'(baddr);
        @(negedge clk);
        redirect_valid = 1'b0;
        check("R7 valid low after redirect", {31'b0, out_valid}, 32'h0);
        check("R6 fetch address after redirect", 32'(fetch_addr), 32'(baddr / 4));
        got   = 0;
        spins = 0;
        phase = first;
        held  = 1'b0;
        held_val = '0;
        while (got < n && spins < 20000) begin
            rdy = ((phase % 3) != 2);
            phase++;
            out_ready = rdy;
            #1;
            if (held) begin
                check("R8 held output", {31'b0, out_valid}, 32'h1);
                check("R8 held output", out_instr, held_val);
            end
            held = 1'b0;
            if (out_valid && rdy) begin
                check(exp_req[first + got], out_instr, exp_q[first + got]);
                got++;
            end else if (out_valid) begin
                held     = 1'b1;
                held_val = out_instr;
            end
            @(negedge clk);
            spins++;
        end
        out_ready = 1'b0;
        if (got < n) begin
            n_chk++;
            n_fail++;
            $display("FAIL R8 stream stalled: got %0d expected %0d", got, n);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        int ph;
        ph = 0;
        forever begin
            @(negedge clk);
            fetch_valid = ((ph % 7) != 4);
            ph++;
        end
    end

    initial begin
        sbits = '0;
        // main block at byte 0: every class interleaved, all lengths across word edges
        for (int i = 0; i < 256; i++) begin
            emit_dict(i, "R3/R5");
            if (i < 64) begin
                int t;
                int j;
                logic [12:0] v;
                t = i % 16;
                j = i / 16;
                v = (j == 0) ? 13'h0000 : (j == 1) ? 13'h1FFF : (j == 2) ? 13'h1000 : 13'(t * 331);
                emit_imm(t, v, "R1/R5");
            end
            if (i < 48) begin
                int c;
                int j;
                logic [15:0] o;
                c = i % 16;
                j = i / 16;
                o = (j == 0) ? 16'h7FFF : (j == 1) ? 16'h8000 : (16'(c * 977) ^ 16'hF00F);
                emit_br(c, o, "R2/R5");
            end
            if (i < 8) emit_raw(raw_val(i), "R4/R5");
        end
        n_main = nexp;
        // redirect targets at byte offsets 1, 2, 3, 0 within a word
        for (int b = 0; b < 4; b++) begin
            align((b + 1) % 4);
            blk_byte[b]  = pos / 8;
            blk_first[b] = nexp;
            case (b)
                0: begin
                    emit_br(3, 16'hFFFE, "R6 branch");
                    emit_br(12, 16'h0001, "R6 branch");
                    emit_raw(32'h0123_4567, "R6 raw");
                end
                1: begin
                    emit_imm(15, 13'h0ABC, "R6 imm");
                    emit_dict(200, "R6 dict");
                    emit_raw(32'h8000_0000, "R6 raw");
                end
                2: begin
                    emit_raw(32'hDEAD_0001, "R6 raw");
                    emit_raw(32'h0000_0001, "R6 raw");
                    emit_imm(7, 13'h1555, "R6 imm");
                end
                default: begin
                    emit_dict(5, "R11 dict after ignored write");
                    emit_imm(1, 13'h0FFF, "R6 imm");
                end
            endcase
            blk_cnt[b] = nexp - blk_first[b];
        end
        for (int w = 0; w < MEM_WORDS; w++) mem[w] = sbits[w*32 +: 32];

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 out_valid after reset", {31'b0, out_valid}, 32'h0);
        check("R10 fetch_ready after reset", {31'b0, fetch_ready}, 32'h0);

        for (int i = 0; i < 256; i++) begin
            cfg_we = 1'b1; cfg_tbl = 1'b0; cfg_addr = 8'(i); cfg_data = dict_val(i);
            @(negedge clk);
        end
        for (int t = 0; t < 16; t++) begin
            cfg_we = 1'b1; cfg_tbl = 1'b1; cfg_addr = 8'(t); cfg_data = tpl_val(t);
            @(negedge clk);
        end
        cfg_we = 1'b0;
        check("R10 idle fetch_ready after table load", {31'b0, fetch_ready}, 32'h0);

        run_block(0, 0, n_main);

        cfg_we = 1'b1; cfg_tbl = 1'b0; cfg_addr = 8'd5; cfg_data = 32'hBAD0_BAD0;
        @(negedge clk);
        cfg_we = 1'b1; cfg_tbl = 1'b1; cfg_addr = 8'd1; cfg_data = 32'h0000_0000;
        @(negedge clk);
        cfg_we = 1'b0;

        for (int b = 0; b < 4; b++) begin
            repeat (4) @(negedge clk);
            run_block(blk_byte[b], blk_first[b], blk_cnt[b]);
        end
        run_block(blk_byte[1], blk_first[1], blk_cnt[1]);
        run_block(0, 0, 40);

        finish_run();
    end
endmodule